// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 32 interrupt request lines and splits each into one of two classes: fast or normal. An enable mask gates each line. Every enabled, asserted fast line raises a single fast request output. Every enabled, asserted normal line raises a single normal request output. Software chooses the class of each line and turns lines on and off through a small word-addressed register bus. Enable bits are turned on by a set register and turned off by a clear register.

Normal requests also pass through sixteen programmable vector slots. Each slot names one request line and holds a handler address. The lowest-numbered enabled slot whose request is live wins, and its address appears both on a port and at a readable vector location. A normal request that no enabled slot matches is still signalled. It is served through a default handler address instead.

Top module: `irq_vector_ctrl`

Register word map (`bus_addr`): 0 normal status (RO), 1 fast status (RO), 2 raw request lines (RO), 3 class, 4 enable (read, write-one-to-set), 5 enable clear (write-one-to-clear, reads 0), 6 vector readout (RO), 7 default address, 16+s slot s address, 32+s slot s control.

## Requirements
- R1: Fast status (word 1) bit n is 1 only when request n is asserted, its enable bit is 1 and its class bit is 1. `fiq_req` is the OR of all fast status bits.
- R2: Normal status (word 0) bit n is 1 only when request n is asserted, its enable bit is 1 and its class bit is 0. `irq_req` is the OR of all normal status bits.
- R3: A write to word 4 sets each enable bit where the written data holds a 1. A write to word 5 clears each enable bit where the data holds a 1. Word 4 reads back the enable mask.
- R4: Word 3 is the class register, read/write. Bit n = 1 selects fast handling for request n, and 0 selects normal handling.
- R5: Slot control word 32+s holds the request number in bits 4:0 and the slot enable in bit 5. Written bits 31:6 are ignored and read back as zero.
- R6: Slot s hits when it is enabled and the normal status bit of its request number is 1. The lowest-numbered hitting slot wins. Its address register (word 16+s) appears on `vec_addr` and at word 6.
- R7: When two or more enabled slots hold the same request number and that request is live, the lower-numbered slot supplies the vector.
- R8: A disabled slot does not mask its request. With no hitting slot, `irq_req` still follows R2, and `vec_addr` and word 6 return the default address register (word 7).
- R9: After reset all enables, classes, slot controls, slot addresses and the default address are zero, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Raw interrupt request lines |
| bus_addr | input | 7 | Register word address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fiq_req | output | 1 | Fast interrupt request |
| irq_req | output | 1 | Normal interrupt request |
| vec_addr | output | 32 | Handler address of the winning slot, or the default address |

## Verification
A register write takes effect at the clock edge that samples `bus_wr`. Status, request outputs and the vector then follow the new state within that same cycle, with no further register stage. Changes on `irq_src` and `bus_addr` reach `fiq_req`, `irq_req`, `vec_addr` and `bus_rdata` combinationally. The bench therefore drives inputs on the falling edge, waits one time unit, and compares. After a write, it compares on the falling edge that follows the sampling rising edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned A_IRQ_ST   = 0;
  localparam int unsigned A_FIQ_ST   = 1;
  localparam int unsigned A_RAW      = 2;
  localparam int unsigned A_CLASS    = 3;
  localparam int unsigned A_EN_SET   = 4;
  localparam int unsigned A_EN_CLR   = 5;
  localparam int unsigned A_VECTOR   = 6;
  localparam int unsigned A_DEFAULT  = 7;
  localparam int unsigned SLOT_ADDR_BASE = 16;
  localparam int unsigned SLOT_CTL_BASE  = 32;

  function automatic logic [31:0] class_split(input logic [31:0] raw,
                                              input logic [31:0] en,
                                              input logic [31:0] cls,
                                              input logic        want_fast);
    return want_fast ? (raw & en & cls) : (raw & en & ~cls);
  endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  parameter int AW     = 7,
  parameter int NUM_W  = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [N_SRC-1:0]  en_q,
  output logic [N_SRC-1:0]  cls_q,
  output logic [DW-1:0]     dflt_q,
  output logic [DW-1:0]     slot_addr_q [N_SLOT],
  output logic [NUM_W-1:0]  slot_num_q  [N_SLOT],
  output logic [N_SLOT-1:0] slot_en_q
);
  import irqv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      cls_q     <= '0;
      dflt_q    <= '0;
      slot_en_q <= '0;
      for (int s = 0; s < N_SLOT; s++) begin
        slot_addr_q[s] <= '0;
        slot_num_q[s]  <= '0;
      end
    end else if (wr) begin
      if (addr == AW'(A_CLASS))   cls_q  <= wdata[N_SRC-1:0];
      if (addr == AW'(A_EN_SET))  en_q   <= en_q | wdata[N_SRC-1:0];
      if (addr == AW'(A_EN_CLR))  en_q   <= en_q & ~wdata[N_SRC-1:0];
      if (addr == AW'(A_DEFAULT)) dflt_q <= wdata;
      for (int s = 0; s < N_SLOT; s++) begin
        if (addr == AW'(SLOT_ADDR_BASE + s)) slot_addr_q[s] <= wdata;
        if (addr == AW'(SLOT_CTL_BASE + s)) begin
          slot_num_q[s] <= wdata[NUM_W-1:0];
          slot_en_q[s]  <= wdata[NUM_W];
        end
      end
    end
  end
endmodule

// File: rtl/irqv_slot_arb.sv
module irqv_slot_arb #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  parameter int NUM_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  irq_st,
  input  logic [NUM_W-1:0]  slot_num [N_SLOT],
  input  logic [N_SLOT-1:0] slot_en,
  input  logic [DW-1:0]     slot_addr [N_SLOT],
  input  logic [DW-1:0]     dflt,
  output logic [N_SLOT-1:0] slot_hit,
  output logic [N_SLOT-1:0] win_oh,
  output logic              any_hit,
  output logic [DW-1:0]     vec
);
  for (genvar s = 0; s < N_SLOT; s++) begin : g_hit
    assign slot_hit[s] = slot_en[s] & irq_st[slot_num[s]];
  end

  assign any_hit = |slot_hit;

  always_comb begin
    logic found;
    found  = 1'b0;
    win_oh = '0;
    vec    = dflt;
    for (int s = 0; s < N_SLOT; s++) begin
      if (slot_hit[s] && !found) begin
        found     = 1'b1;
        win_oh[s] = 1'b1;
        vec       = slot_addr[s];
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  parameter int AW     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_src,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             fiq_req,
  output logic             irq_req,
  output logic [DW-1:0]    vec_addr
);
  import irqv_pkg::*;
  localparam int NUM_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  en_q, cls_q, fiq_st, irq_st;
  logic [DW-1:0]     dflt_q;
  logic [DW-1:0]     slot_addr_q [N_SLOT];
  logic [NUM_W-1:0]  slot_num_q  [N_SLOT];
  logic [N_SLOT-1:0] slot_en_q, slot_hit, win_oh;
  logic              any_hit;

  irqv_regs #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .AW(AW), .NUM_W(NUM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .en_q(en_q), .cls_q(cls_q), .dflt_q(dflt_q),
    .slot_addr_q(slot_addr_q), .slot_num_q(slot_num_q), .slot_en_q(slot_en_q)
  );

  assign fiq_st  = N_SRC'(class_split(32'(irq_src), 32'(en_q), 32'(cls_q), 1'b1));
  assign irq_st  = N_SRC'(class_split(32'(irq_src), 32'(en_q), 32'(cls_q), 1'b0));
  assign fiq_req = |fiq_st;
  assign irq_req = |irq_st;

  irqv_slot_arb #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .NUM_W(NUM_W)) u_arb (
    .irq_st(irq_st), .slot_num(slot_num_q), .slot_en(slot_en_q),
    .slot_addr(slot_addr_q), .dflt(dflt_q),
    .slot_hit(slot_hit), .win_oh(win_oh), .any_hit(any_hit), .vec(vec_addr)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_IRQ_ST))  bus_rdata = DW'(irq_st);
    if (bus_addr == AW'(A_FIQ_ST))  bus_rdata = DW'(fiq_st);
    if (bus_addr == AW'(A_RAW))     bus_rdata = DW'(irq_src);
    if (bus_addr == AW'(A_CLASS))   bus_rdata = DW'(cls_q);
    if (bus_addr == AW'(A_EN_SET))  bus_rdata = DW'(en_q);
    if (bus_addr == AW'(A_VECTOR))  bus_rdata = vec_addr;
    if (bus_addr == AW'(A_DEFAULT)) bus_rdata = dflt_q;
    for (int s = 0; s < N_SLOT; s++) begin
      if (bus_addr == AW'(SLOT_ADDR_BASE + s)) bus_rdata = slot_addr_q[s];
      if (bus_addr == AW'(SLOT_CTL_BASE + s))  bus_rdata = DW'({slot_en_q[s], slot_num_q[s]});
    end
  end
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  parameter int AW     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  irq_src,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              fiq_req,
  input logic              irq_req,
  input logic [DW-1:0]     vec_addr,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  cls_q,
  input logic [N_SRC-1:0]  fiq_st,
  input logic [N_SRC-1:0]  irq_st,
  input logic [DW-1:0]     dflt_q,
  input logic [N_SLOT-1:0] slot_hit,
  input logic [N_SLOT-1:0] win_oh,
  input logic              any_hit
);
  import irqv_pkg::*;

  // R1 and R2: a line never shows in both classes
  a_r2_class_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_st & irq_st) == '0);

  // R1: a fast request needs an asserted, enabled fast line
  a_r1_fiq_source: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req |-> ((irq_src & en_q & cls_q) != '0));

  // R3: a clear write leaves none of the written bits enabled
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(A_EN_CLR)) |=> ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

  // R6: at most one winning slot
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  // R6: any slot hit implies a normal request
  a_r6_hit_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> irq_req);

  // R7: no hitting slot below the winner
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh != '0) |-> (((win_oh - 1'b1) & slot_hit) == '0));

  // R8: no hit falls back to the default address
  a_r8_default_vector: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (vec_addr == dflt_q));
endmodule

bind irq_vector_ctrl irqv_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .fiq_req(fiq_req), .irq_req(irq_req), .vec_addr(vec_addr),
  .en_q(en_q), .cls_q(cls_q), .fiq_st(fiq_st), .irq_st(irq_st), .dflt_q(dflt_q),
  .slot_hit(slot_hit), .win_oh(win_oh), .any_hit(any_hit)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_req, irq_req;
  logic [31:0] vec_addr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  bit [31:0] m_en, m_cls, m_dflt;
  bit [4:0]  m_num [16];
  bit        m_sen [16];
  bit [31:0] m_saddr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_req(fiq_req), .irq_req(irq_req),
    .vec_addr(vec_addr)
  );

  function automatic bit [31:0] want_fast();
    return irq_src & m_en & m_cls;
  endfunction

  function automatic bit [31:0] want_norm();
    return irq_src & m_en & ~m_cls;
  endfunction

  function automatic bit [31:0] want_vec();
    bit [31:0] n;
    n = want_norm();
    for (int s = 0; s < 16; s++)
      if (m_sen[s] && n[m_num[s]]) return m_saddr[s];
    return m_dflt;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input bit [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    if (a == 3) m_cls = d;
    if (a == 4) m_en = m_en | d;
    if (a == 5) m_en = m_en & ~d;
    if (a == 7) m_dflt = d;
    if (a >= 16 && a < 32) m_saddr[a-16] = d;
    if (a >= 32 && a < 48) begin m_num[a-32] = d[4:0]; m_sen[a-32] = d[5]; end
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a);
    #1 d = bus_rdata;
  endtask

  task automatic set_src(input bit [31:0] v);
    @(negedge clk);
    irq_src = v;
    #1;
  endtask

  task automatic check_ports(input string tag);
    @(negedge clk); #1;
    check({tag, " R1 fiq_req"}, 32'(fiq_req), 32'(want_fast() != 0));
    check({tag, " R2 irq_req"}, 32'(irq_req), 32'(want_norm() != 0));
    check({tag, " R6 vec_addr"}, vec_addr, want_vec());
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20250611));
    m_en = 0; m_cls = 0; m_dflt = 0;
    for (int s = 0; s < 16; s++) begin m_num[s] = 0; m_sen[s] = 0; m_saddr[s] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    set_src(32'hFFFF_FFFF);
    check("R9 fiq_req after reset", 32'(fiq_req), 0);
    check("R9 irq_req after reset", 32'(irq_req), 0);
    bus_read(4, rd);  check("R9 enable reset", rd, 0);
    bus_read(3, rd);  check("R9 class reset", rd, 0);
    bus_read(7, rd);  check("R9 default reset", rd, 0);
    bus_read(35, rd); check("R9 slot ctl reset", rd, 0);
    bus_read(20, rd); check("R9 slot addr reset", rd, 0);
    set_src(32'h0);

    // R3: set and clear of enables
    bus_write(4, 32'h0000_00F0);
    bus_read(4, rd); check("R3 enable set", rd, 32'h0000_00F0);
    bus_write(5, 32'h0000_0030);
    bus_read(4, rd); check("R3 enable clear", rd, 32'h0000_00C0);
    bus_read(5, rd); check("R3 clear word reads zero", rd, 0);

    // R4 / R1 / R2: class split
    bus_write(3, 32'h0000_0080);
    bus_read(3, rd); check("R4 class readback", rd, 32'h0000_0080);
    set_src(32'h0000_00C3);
    bus_read(1, rd); check("R1 fast status", rd, 32'h0000_0080);
    bus_read(0, rd); check("R2 normal status", rd, 32'h0000_0040);
    bus_read(2, rd); check("R2 raw readout", rd, 32'h0000_00C3);
    check("R1 fiq_req high", 32'(fiq_req), 1);
    check("R2 irq_req high", 32'(irq_req), 1);

    // R5: upper control bits ignored
    bus_write(35, 32'hFFFF_FFC6);
    bus_read(35, rd); check("R5 ctl bits 31:6 ignored", rd, 32'h0000_0006);

    // R8: disabled slot leaves request live, default vector
    bus_write(7, 32'hDEAD_0000);
    bus_write(19, 32'h1000_0300);
    check("R8 irq_req with disabled slot", 32'(irq_req), 1);
    check("R8 default on port", vec_addr, 32'hDEAD_0000);
    bus_read(6, rd); check("R8 default at vector word", rd, 32'hDEAD_0000);

    // R6: enabled slot supplies vector
    bus_write(35, 32'h0000_0026);
    check("R6 slot vector on port", vec_addr, 32'h1000_0300);
    bus_read(6, rd); check("R6 slot vector at word", rd, 32'h1000_0300);

    // R7: duplicates resolve to lower slot
    bus_write(25, 32'h0000_0900);
    bus_write(41, 32'h0000_0026);
    check("R7 higher duplicate loses", vec_addr, 32'h1000_0300);
    bus_write(17, 32'h0000_0100);
    bus_write(33, 32'h0000_0026);
    check("R7 lower duplicate wins", vec_addr, 32'h0000_0100);

    // R6: a slot naming a fast line never hits
    bus_write(16, 32'h0000_0AAA);
    bus_write(32, 32'h0000_0027);
    check("R6 fast line does not vector", vec_addr, 32'h0000_0100);

    // R8: request withdrawn -> default
    set_src(32'h0000_0080);
    check("R8 no normal request default", vec_addr, 32'hDEAD_0000);
    check("R8 irq_req low", 32'(irq_req), 0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      bit [31:0] w;
      op = int'($urandom % 8);
      w  = $urandom;
      case (op)
        0: bus_write(3, w & $urandom);
        1: bus_write(4, w);
        2: bus_write(5, w & $urandom);
        3: bus_write(7, w);
        4: bus_write(16 + int'($urandom % 16), w);
        5: bus_write(32 + int'($urandom % 16), w);
        default: set_src(w & $urandom);
      endcase
      check_ports("random");
      if (i % 10 == 0) begin
        bus_read(0, rd); check("R2 random normal status", rd, want_norm());
        bus_read(1, rd); check("R1 random fast status", rd, want_fast());
        bus_read(6, rd); check("R6 random vector word", rd, want_vec());
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule